// File: doc/BRIEF.md
# Two-Wire Serial Slave Controller

This block is the slave end of a two-wire serial bus (I2C-style). It samples the clock and data lines and finds the bus conditions: START, repeated START and STOP. After each START it compares a 7-bit address with a programmable slave address. On a match it acknowledges and then moves whole bytes in one of two directions. In a write transfer, bytes from the master go into a receive holding register. In a read transfer, bytes that the host has placed in a transmit holding register go out to the master.

The pads are open-drain. They are modelled as two output enables: while an enable is high, the slave pulls that line low. The host side uses plain strobes:
- `txWrite` loads the transmit holding register.
- `rxRead` consumes the receive holding register.

Six status outputs show the state of the bus access. If the host has not serviced a holding register by the time the bus needs it, the slave holds the clock line low until the host does. Address 0 (general call) is accepted and flagged. The host decides what the bytes that follow it mean.

Top module: `i2c_slave_ctl`

## Requirements
- R1: Both bus inputs pass through a two-flop synchronizer.
  - A START is SDA falling while SCL is high. A STOP is SDA rising while SCL is high.
  - SDA changes while SCL is low are data and never end an access.
- R2: After every START or repeated START, the slave shifts in 7 address bits MSB first, then the R/W bit (1 = master reads).
  - On a match with `ownAddr`, the slave sets `accActive`, copies R/W into `readDir`, and pulls SDA low during the ninth clock (ACK).
  - A non-matching address gets no ACK and leaves `accActive` low.
- R3: Address 0 is accepted as a general call whatever `ownAddr` holds, and it sets `genCall`. A later match on `ownAddr` clears `genCall`.
- R4: In a write transfer, each byte is received MSB first and acknowledged. It is placed in `rxData`, and `rxReady` is set. A one-cycle `rxRead` pulse clears `rxReady`.
- R5: Receive stretching.
  - If a byte completes while `rxReady` is still set and `rxRead` is low in that cycle, the slave drives `sclOe` and `clkWait` from the next SCL falling edge until `rxRead`. The held byte then appears in `rxData` with `rxReady` set, and `sclOe` drops one clock after the `rxRead` pulse.
  - An `rxRead` in the very cycle the byte completes loads the new byte at once, with no stretch.
- R6: In a read transfer, host bytes are sent MSB first, and SDA is released in the ninth clock. A master ACK (0) starts the next byte. A master NACK (1) makes the slave release SDA and ignore clocks until the next START or STOP.
- R7: Transmit stretching. If the transmit holding register is empty when a byte must start, the slave drives `sclOe` and `clkWait` until `txWrite`. It releases one clock after the `txWrite` pulse and sends the written byte.
- R8: Ending an access.
  - A STOP during an access clears `accActive` and sets `xferDone`.
  - A repeated START with a non-matching address does the same.
  - A repeated START with the matching address keeps `accActive` set and updates `readDir`.
- R9: `xferDone` is cleared when a new matching address is decoded.
- R10: After reset, all status outputs and both output enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Sampled level of the clock line |
| sdaIn | input | 1 | Sampled level of the data line |
| sclOe | output | 1 | Pull the clock line low (stretching) |
| sdaOe | output | 1 | Pull the data line low |
| ownAddr | input | DATA_W-1 | Programmed slave address |
| txData | input | DATA_W | Byte for the transmit holding register |
| txWrite | input | 1 | Load strobe for `txData` |
| rxData | output | DATA_W | Receive holding register |
| rxRead | input | 1 | Host consumes `rxData` |
| accActive | output | 1 | Access in progress |
| readDir | output | 1 | Access direction, 1 = master reads |
| rxReady | output | 1 | `rxData` holds an unread byte |
| xferDone | output | 1 | Last access has ended |
| genCall | output | 1 | Last matching address was the general call |
| clkWait | output | 1 | Clock line held low waiting for the host |

## Verification
Two functions can fall in the same cycle: the host consuming the receive register, and a new byte completing into that same register. The bench provokes this by timing an `rxRead` pulse to the cycle in which the eighth rising SCL edge reaches the decoder, counting the synchronizer stages. It judges the result by three things: `rxReady` stays set, `rxData` switches to the new byte, and `clkWait` never rises during that byte. The late case is also covered. There the read comes after the byte is parked, and the release must follow the pulse by one clock with the parked byte delivered.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RXB,
    ST_PREACK,
    ST_RXHOLD,
    ST_ACKR,
    ST_ACKF,
    ST_TXB,
    ST_TXLAST,
    ST_MACKR,
    ST_MACKF,
    ST_TXHOLD
  } ctlState_t;

  // Decoded bus conditions, one cycle wide
  typedef struct packed {
    logic start;
    logic stop;
    logic sclRise;
    logic sclFall;
    logic sdaBit;
  } busEvent_t;

  // Control-to-datapath strobes
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic takeTx;
    logic loadRxNow;
    logic loadRxPend;
  } dpStrobe_t;

endpackage

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  input  logic              rxRead,
  output busEvent_t         busEv,
  output logic [DATA_W-1:0] byteIn,
  output logic              txBit,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              txFull
);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic sclNow, sdaNow, sclPrev, sdaPrev;
  logic [DATA_W-1:0] shiftReg, txHold;

  // Synchronizers; the idle bus level is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow = sclPipe[SYNC_STAGES-1];
  assign sdaNow = sdaPipe[SYNC_STAGES-1];

  always_comb begin
    busEv.start   = sclNow & sclPrev & sdaPrev & ~sdaNow;
    busEv.stop    = sclNow & sclPrev & ~sdaPrev & sdaNow;
    busEv.sclRise = sclNow & ~sclPrev;
    busEv.sclFall = ~sclNow & sclPrev;
    busEv.sdaBit  = sdaNow;
  end

  assign byteIn = {shiftReg[DATA_W-2:0], sdaNow};
  assign txBit  = shiftReg[DATA_W-1];

  // Shared shift register: serial in on receive, serial out on transmit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '1;
    end else if (strobe.takeTx) begin
      shiftReg <= txFull ? txHold : txData;
    end else if (strobe.shiftIn) begin
      shiftReg <= byteIn;
    end else if (strobe.shiftOut) begin
      shiftReg <= {shiftReg[DATA_W-2:0], 1'b1};
    end
  end

  // Transmit holding register; a write in the take cycle goes straight through
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txHold <= '0;
      txFull <= 1'b0;
    end else if (strobe.takeTx) begin
      if (txFull) begin
        txFull <= txWrite;
        if (txWrite) txHold <= txData;
      end
    end else if (txWrite) begin
      txHold <= txData;
      txFull <= 1'b1;
    end
  end

  // Receive holding register; a load wins over a same-cycle read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxData  <= '0;
      rxReady <= 1'b0;
    end else if (strobe.loadRxNow) begin
      rxData  <= byteIn;
      rxReady <= 1'b1;
    end else if (strobe.loadRxPend) begin
      rxData  <= shiftReg;
      rxReady <= 1'b1;
    end else if (rxRead) begin
      rxReady <= 1'b0;
    end
  end

endmodule

// File: rtl/i2cs_control.sv
module i2cs_control
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvent_t         busEv,
  input  logic [DATA_W-1:0] byteIn,
  input  logic [DATA_W-2:0] ownAddr,
  input  logic              rxReady,
  input  logic              txFull,
  input  logic              rxRead,
  input  logic              txWrite,
  output dpStrobe_t         strobe,
  output logic              accActive,
  output logic              readDir,
  output logic              genCall,
  output logic              xferDone,
  output logic              clkWait,
  output logic              ackDrive,
  output logic              txDrive
);

  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

  ctlState_t state, stNext;
  logic [CNT_W-1:0] bitCnt, cntNext;
  logic accN, rdN, gcN, doneN, rxPend, pendN;
  logic addrHit, addrGen, lastBit;

  assign addrHit = (byteIn[DATA_W-1:1] == ownAddr);
  assign addrGen = (byteIn[DATA_W-1:1] == '0);
  assign lastBit = (bitCnt == LAST_BIT);

  always_comb begin
    stNext  = state;
    cntNext = bitCnt;
    strobe  = '0;
    accN    = accActive;
    rdN     = readDir;
    gcN     = genCall;
    doneN   = xferDone;
    pendN   = rxPend;

    // A parked receive byte moves over as soon as the host reads
    if (rxPend && rxRead) begin
      strobe.loadRxPend = 1'b1;
      pendN             = 1'b0;
    end

    if (busEv.stop) begin
      stNext = ST_IDLE;
      if (accActive) begin
        accN  = 1'b0;
        doneN = 1'b1;
      end
    end else if (busEv.start) begin
      stNext  = ST_ADDR;
      cntNext = '0;
    end else begin
      unique case (state)
        ST_ADDR: if (busEv.sclRise) begin
          strobe.shiftIn = 1'b1;
          cntNext        = bitCnt + 1'b1;
          if (lastBit) begin
            if (addrHit || addrGen) begin
              accN   = 1'b1;
              rdN    = byteIn[0];
              gcN    = addrGen;
              doneN  = 1'b0;
              stNext = ST_PREACK;
            end else begin
              stNext = ST_IDLE;
              if (accActive) begin
                accN  = 1'b0;
                doneN = 1'b1;
              end
            end
          end
        end
        ST_RXB: if (busEv.sclRise) begin
          strobe.shiftIn = 1'b1;
          cntNext        = bitCnt + 1'b1;
          if (lastBit) begin
            if (rxReady && !rxRead) pendN = 1'b1;
            else strobe.loadRxNow = 1'b1;
            stNext = ST_PREACK;
          end
        end
        ST_PREACK: if (busEv.sclFall) begin
          stNext = (rxPend && !rxRead) ? ST_RXHOLD : ST_ACKR;
        end
        ST_RXHOLD: if (rxRead) stNext = ST_ACKR;
        ST_ACKR: if (busEv.sclRise) stNext = ST_ACKF;
        ST_ACKF: if (busEv.sclFall) begin
          cntNext = '0;
          if (!readDir) begin
            stNext = ST_RXB;
          end else if (txFull || txWrite) begin
            strobe.takeTx = 1'b1;
            stNext        = ST_TXB;
          end else begin
            stNext = ST_TXHOLD;
          end
        end
        ST_TXHOLD: if (txWrite) begin
          strobe.takeTx = 1'b1;
          cntNext       = '0;
          stNext        = ST_TXB;
        end
        ST_TXB: begin
          if (busEv.sclRise) begin
            cntNext = bitCnt + 1'b1;
            if (lastBit) stNext = ST_TXLAST;
          end else if (busEv.sclFall) begin
            strobe.shiftOut = 1'b1;
          end
        end
        ST_TXLAST: if (busEv.sclFall) stNext = ST_MACKR;
        ST_MACKR: if (busEv.sclRise) begin
          stNext = busEv.sdaBit ? ST_IDLE : ST_MACKF;
        end
        ST_MACKF: if (busEv.sclFall) begin
          cntNext = '0;
          if (txFull || txWrite) begin
            strobe.takeTx = 1'b1;
            stNext        = ST_TXB;
          end else begin
            stNext = ST_TXHOLD;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      accActive <= 1'b0;
      readDir   <= 1'b0;
      genCall   <= 1'b0;
      xferDone  <= 1'b0;
      rxPend    <= 1'b0;
    end else begin
      state     <= stNext;
      bitCnt    <= cntNext;
      accActive <= accN;
      readDir   <= rdN;
      genCall   <= gcN;
      xferDone  <= doneN;
      rxPend    <= pendN;
    end
  end

  assign clkWait  = (state == ST_RXHOLD) || (state == ST_TXHOLD);
  assign ackDrive = (state == ST_ACKR) || (state == ST_ACKF);
  assign txDrive  = (state == ST_TXB) || (state == ST_TXLAST);

endmodule

// File: rtl/i2c_slave_ctl.sv
module i2c_slave_ctl
  import i2cs_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclOe,
  output logic              sdaOe,
  input  logic [DATA_W-2:0] ownAddr,
  input  logic [DATA_W-1:0] txData,
  input  logic              txWrite,
  output logic [DATA_W-1:0] rxData,
  input  logic              rxRead,
  output logic              accActive,
  output logic              readDir,
  output logic              rxReady,
  output logic              xferDone,
  output logic              genCall,
  output logic              clkWait
);

  dpStrobe_t         strobe;
  busEvent_t         busEv;
  logic [DATA_W-1:0] byteIn;
  logic              txBit, txFull, ackDrive, txDrive;

  i2cs_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .sclIn   (sclIn),
    .sdaIn   (sdaIn),
    .strobe  (strobe),
    .txData  (txData),
    .txWrite (txWrite),
    .rxRead  (rxRead),
    .busEv   (busEv),
    .byteIn  (byteIn),
    .txBit   (txBit),
    .rxData  (rxData),
    .rxReady (rxReady),
    .txFull  (txFull)
  );

  i2cs_control #(.DATA_W(DATA_W)) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .busEv     (busEv),
    .byteIn    (byteIn),
    .ownAddr   (ownAddr),
    .rxReady   (rxReady),
    .txFull    (txFull),
    .rxRead    (rxRead),
    .txWrite   (txWrite),
    .strobe    (strobe),
    .accActive (accActive),
    .readDir   (readDir),
    .genCall   (genCall),
    .xferDone  (xferDone),
    .clkWait   (clkWait),
    .ackDrive  (ackDrive),
    .txDrive   (txDrive)
  );

  assign sclOe = clkWait;
  assign sdaOe = ackDrive | (txDrive & ~txBit);

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic clk,
  input logic rstN,
  input logic sclOe,
  input logic sdaOe,
  input logic rxRead,
  input logic txWrite,
  input logic accActive,
  input logic readDir,
  input logic rxReady,
  input logic xferDone
);

  // R2: the data line is only pulled inside an accepted access
  a_r2_drive_in_access: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> accActive);

  // R5: the clock line is only held during an access
  a_r5_stretch_in_access: assert property (@(posedge clk) disable iff (!rstN)
    sclOe |-> accActive);

  // R5: a receive-side stretch implies an unread byte is pending
  a_r5_rx_hold_full: assert property (@(posedge clk) disable iff (!rstN)
    (sclOe && !readDir) |-> rxReady);

  // R7: a stretch ends only after the host serviced a register
  a_r7_release_on_service: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclOe) |-> ($past(rxRead) || $past(txWrite)));

  // R4: receive-ready rises only in master-write transfers
  a_r4_ready_on_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxReady) |-> !readDir);

  // R8: the end of an access raises transfer-complete
  a_r8_done_on_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(accActive) |-> xferDone);

  // R9: a new access starts with transfer-complete cleared
  a_r9_done_clear: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accActive) |-> !xferDone);

endmodule

bind i2c_slave_ctl i2cs_checker u_chk (.*);

// File: tb/i2c_slave_ctl_bench.sv
module i2c_slave_ctl_bench;

  localparam int Q = 10;
  localparam logic [6:0] OWN = 7'h42;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sclLine, sdaLine;
  logic sclOe, sdaOe;
  logic [7:0] txData = 8'h00;
  logic txWrite = 1'b0, rxRead = 1'b0;
  logic [7:0] rxData;
  logic accActive, readDir, rxReady, xferDone, genCall, clkWait;

  assign sclLine = sclM & ~sclOe;
  assign sdaLine = sdaM & ~sdaOe;

  i2c_slave_ctl u_i2c_slave_ctl (
    .clk(clk), .rstN(rstN), .sclIn(sclLine), .sdaIn(sdaLine),
    .sclOe(sclOe), .sdaOe(sdaOe), .ownAddr(OWN),
    .txData(txData), .txWrite(txWrite), .rxData(rxData), .rxRead(rxRead),
    .accActive(accActive), .readDir(readDir), .rxReady(rxReady),
    .xferDone(xferDone), .genCall(genCall), .clkWait(clkWait)
  );

  int errors = 0;
  int checks = 0;
  int waitCycles = 0;
  logic [7:0] expRx[$];
  logic [7:0] expTx[$];

  always @(negedge clk) if (clkWait) waitCycles++;

  task automatic checkEq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ();
  endtask

  task automatic clockBit(input logic b, input bit readAtRise, output logic r);
    sdaM = b; waitQ();
    sclM = 1'b1;
    if (readAtRise) begin
      // rxRead reaches the design in the cycle the 8th rising edge is decoded
      repeat (2) @(posedge clk);
      @(negedge clk) rxRead = 1'b1;
      @(negedge clk) rxRead = 1'b0;
    end
    @(negedge clk);
    while (sclLine == 1'b0) @(negedge clk);
    waitQ();
    r = sdaLine;
    sclM = 1'b0; waitQ();
  endtask

  task automatic writeByte(input logic [7:0] b, input bit rdOn8, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clockBit(b[i], rdOn8 && (i == 0), r);
    clockBit(1'b1, 1'b0, ack);
  endtask

  task automatic readByte(input logic mAck, output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, 1'b0, r);
      d[i] = r;
    end
    clockBit(mAck, 1'b0, r);
  endtask

  task automatic sendAddr(input logic [6:0] a, input logic rw, output logic ack);
    writeByte({a, rw}, 1'b0, ack);
  endtask

  task automatic sendData(input logic [7:0] b, input string req);
    logic ack;
    expRx.push_back(b);
    writeByte(b, 1'b0, ack);
    checkEq({req, " data ACK"}, 32'(ack), 0);
  endtask

  task automatic recvData(input logic mAck, input string req);
    logic [7:0] d, e;
    readByte(mAck, d);
    e = expTx.pop_front();
    checkEq({req, " tx byte"}, 32'(d), 32'(e));
  endtask

  task automatic hostWrite(input logic [7:0] b);
    @(negedge clk);
    txData = b; txWrite = 1'b1;
    expTx.push_back(b);
    @(negedge clk);
    txWrite = 1'b0;
  endtask

  task automatic hostRead(input string req);
    logic [7:0] e;
    @(negedge clk);
    checkEq({req, " rxReady before read"}, 32'(rxReady), 1);
    e = expRx.pop_front();
    checkEq({req, " rxData"}, 32'(rxData), 32'(e));
    rxRead = 1'b1;
    @(negedge clk);
    rxRead = 1'b0;
  endtask

  task automatic awaitWait();
    int n = 0;
    while (!clkWait && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    logic a;
    logic [7:0] d;
    int w0;
    repeat (5) @(negedge clk);
    // R10: reset state
    checkEq("R10 flags and enables", {accActive, readDir, rxReady, xferDone, genCall, clkWait, sclOe, sdaOe}, 0);
    rstN = 1'b1;
    waitQ();

    // R2: foreign address is not acknowledged
    busStart();
    sendAddr(7'h13, 1'b0, a);
    checkEq("R2 mismatch NACK", 32'(a), 1);
    checkEq("R2 mismatch no access", 32'(accActive), 0);
    busStop();

    // R2/R4/R1/R8: simple write
    busStart();
    sendAddr(OWN, 1'b0, a);
    checkEq("R2 match ACK", 32'(a), 0);
    checkEq("R2 access and direction", {accActive, readDir}, 2'b10);
    checkEq("R9 done cleared at new access", 32'(xferDone), 0);
    sendData(8'hA5, "R4");
    checkEq("R1 data-phase SDA edges keep access", 32'(accActive), 1);
    hostRead("R4");
    checkEq("R4 rxReady cleared by read", 32'(rxReady), 0);
    busStop();
    checkEq("R8 stop ends access", {accActive, xferDone}, 2'b01);

    // R5: receive stretch and release
    busStart();
    sendAddr(OWN, 1'b0, a);
    sendData(8'h3C, "R5");
    fork
      sendData(8'hC3, "R5");
      begin
        awaitWait();
        checkEq("R5 stretch asserted", {sclOe, clkWait}, 2'b11);
        hostRead("R5");
        checkEq("R5 release one clock after read", {sclOe, clkWait}, 2'b00);
      end
    join
    hostRead("R5 parked byte");
    // R5: read in the same cycle the byte completes
    sendData(8'h5E, "R5");
    @(negedge clk);
    checkEq("R5 before same-cycle read", 32'(rxData), 8'h5E);
    void'(expRx.pop_front());
    expRx.push_back(8'h7B);
    w0 = waitCycles;
    writeByte(8'h7B, 1'b1, a);
    checkEq("R5 same-cycle ACK", 32'(a), 0);
    checkEq("R5 same-cycle no stretch", waitCycles - w0, 0);
    hostRead("R5 same-cycle");
    busStop();

    // R6/R7: read transfer with transmit stretch
    hostWrite(8'h96);
    busStart();
    sendAddr(OWN, 1'b1, a);
    checkEq("R2 read ACK", 32'(a), 0);
    checkEq("R6 read direction", 32'(readDir), 1);
    recvData(1'b0, "R6");
    fork
      recvData(1'b1, "R7");
      begin
        awaitWait();
        checkEq("R7 stretch asserted", {sclOe, clkWait}, 2'b11);
        hostWrite(8'h5A);
        checkEq("R7 release one clock after write", {sclOe, clkWait}, 2'b00);
      end
    join
    readByte(1'b1, d);
    checkEq("R6 clocks after NACK ignored", 32'(d), 8'hFF);
    busStart();
    sendAddr(7'h13, 1'b0, a);
    checkEq("R8 restart mismatch NACK", 32'(a), 1);
    checkEq("R8 restart mismatch ends access", {accActive, xferDone}, 2'b01);
    busStop();

    // R8: restart with the own address keeps the access
    busStart();
    sendAddr(OWN, 1'b0, a);
    sendData(8'h11, "R8");
    hostRead("R8");
    hostWrite(8'h22);
    busStart();
    sendAddr(OWN, 1'b1, a);
    checkEq("R8 restart match keeps access", {accActive, readDir, xferDone}, 3'b110);
    recvData(1'b1, "R8");
    busStop();
    checkEq("R8 stop after read", {accActive, xferDone}, 2'b01);

    // R3/R9: general call, then a normal access
    busStart();
    writeByte(8'h00, 1'b0, a);
    checkEq("R3 general call ACK", 32'(a), 0);
    checkEq("R3 general call flag", {accActive, genCall}, 2'b11);
    sendData(8'h06, "R3");
    hostRead("R3");
    busStop();
    busStart();
    sendAddr(OWN, 1'b0, a);
    checkEq("R3 own match clears general call", 32'(genCall), 0);
    checkEq("R9 done cleared", 32'(xferDone), 0);
    busStop();

    waitQ();
    finishRun();
  end

endmodule